// File: doc/BRIEF.md
# Parallel Camera Pixel Capture

This block sits between a parallel image sensor and a memory writer. On each pixel clock it samples a raw sample bus together with a line-valid and a frame-valid strobe. It keeps the eight most significant bits of every sample. It can limit capture to a rectangular window of the frame and can keep only every second byte of that window. Kept bytes are packed four to a 32-bit word, and each word is offered on a valid/ready output.

Software programs the block through a small register port. The port sets the active level of each sync input, the window origin and size, byte decimation, single-frame or free-running capture, and a per-frame word budget. Three sticky status flags report frame completion, lost words, and a frame that ended on an incomplete word. Everything runs on the pixel clock.

Top module: `cam_capture`

## Requirements
- R1: Each captured byte is `pix_data[9:2]`. The two least significant bits never reach the output.
- R2: Bytes are packed in arrival order, with the first byte in bits 7:0 and the fourth in bits 31:24. A word appears on `word_data` with `word_valid` high on the clock after its fourth byte. It stays there unchanged until the cycle in which `word_ready` is high.
- R3: CTRL (address 0) bit 3 selects the active level of `line_sync` and bit 4 selects the active level of `frame_sync`. A value of 1 means high is active and 0 means low is active. The inactive level is blanking.
- R4: The column index starts at 0 on the first active cycle of a line. The row index starts at 0 at frame start and increases by one at the end of each active line. A sample is kept only if col is in [X0, X0+W) and row is in [Y0, Y0+H). ORIGIN (address 2) holds X0 in bits 15:0 and Y0 in bits 31:16. SIZE (address 3) holds W in bits 15:0 and H in bits 31:16.
- R5: When CTRL bit 2 is set, a sample inside the window is kept only if col−X0 is even.
- R6: CTRL bit 0 enables capture. Capture begins at the first frame start seen while the bit is set, so a frame already in progress is skipped. With CTRL bit 1 set (continuous), every following frame is captured.
- R7: With CTRL bit 1 clear (snapshot), CTRL bit 0 clears itself when the captured frame ends. No further frame is captured until software sets the bit again.
- R8: When frame-valid leaves its active level at the end of a captured frame, STATUS (address 1) bit 0 is set. Writing 1 to a STATUS bit clears it.
- R9: LIMIT (address 4, bits 15:0, reset value 0xFFFF) caps the number of words sent per frame. A word that completes after the cap has been reached is dropped, and STATUS bit 1 is set.
- R10: A word that completes while the previous word is still waiting (`word_valid` high, `word_ready` low) is dropped, and STATUS bit 1 is set.
- R11: If a captured frame ends with 1 to 3 bytes packed, those bytes are discarded and STATUS bit 2 is set. The next frame starts packing at byte 0.
- R12: After reset, `word_valid` is 0, CTRL and STATUS read 0, and LIMIT reads 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_data | input | 10 | Raw sensor sample |
| line_sync | input | 1 | Line-valid strobe, level programmable |
| frame_sync | input | 1 | Frame-valid strobe, level programmable |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data, combinational from `cfg_addr` |
| word_valid | output | 1 | Packed word available |
| word_ready | input | 1 | Consumer accepts the word |
| word_data | output | 32 | Packed word, first byte in bits 7:0 |

## Verification
A wrong column or row count, or a misplaced window edge, shows as wrong bytes in the first word of the affected line, within four kept pixels. A byte-slot counter that is out of step rotates every later word of the frame and sets the partial-word flag at the next frame end. A bad enable or capture state shows as a whole frame of missing or extra words, or as a done flag that is missing or unexpected. A broken stall hold shows on the next clock, as a changed `word_data` while `word_valid` is high and `word_ready` is low.

// File: rtl/cam_capture.sv
`timescale 1ns/1ps
module cam_capture #(
  parameter int RAW_W   = 10,
  parameter int COORD_W = 16,
  parameter int WCNT_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [RAW_W-1:0] pix_data,
  input  logic             line_sync,
  input  logic             frame_sync,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_addr,
  input  logic [31:0]      cfg_wdata,
  output logic [31:0]      cfg_rdata,
  output logic             word_valid,
  input  logic             word_ready,
  output logic [31:0]      word_data
);
  localparam logic [2:0] A_CTRL = 3'd0, A_STAT = 3'd1, A_ORG = 3'd2, A_SIZE = 3'd3, A_LIM = 3'd4;

  logic en, cont, skip, lpol, fpol;
  logic [COORD_W-1:0] x0, y0, w, h, col, row;
  logic [WCNT_W-1:0] limit, wcnt;
  logic st_done, st_ovr, st_part;
  logic capt, line_q, frame_q;
  logic [1:0] bidx;
  logic [23:0] pack;

  logic line_act, frame_act, f_start, f_end, take, live;
  logic [COORD_W-1:0] cur_row, rel_col, rel_row;
  logic col_ok, row_ok, skip_ok, accept, complete, pending, emit, drop, fin;
  logic [7:0] byte_in;
  logic stat_wr;
  logic sink_unused;

  assign line_act  = lpol ? line_sync  : ~line_sync;
  assign frame_act = fpol ? frame_sync : ~frame_sync;
  assign f_start   = frame_act & ~frame_q;
  assign f_end     = ~frame_act & frame_q;
  assign take      = en & f_start;
  assign live      = capt | take;
  assign fin       = capt & f_end;

  assign cur_row = take ? '0 : row;
  assign rel_col = col - x0;
  assign rel_row = cur_row - y0;
  assign col_ok  = (col >= x0) && (rel_col < w);
  assign row_ok  = (cur_row >= y0) && (rel_row < h);
  assign skip_ok = ~skip | ~rel_col[0];
  assign accept  = live & frame_act & line_act & col_ok & row_ok & skip_ok;

  assign byte_in  = pix_data[RAW_W-1 -: 8];
  assign complete = accept & (bidx == 2'd3);
  assign pending  = word_valid & ~word_ready;
  assign emit     = complete & ~pending & (wcnt != limit);
  assign drop     = complete & ~emit;
  assign stat_wr  = cfg_we & (cfg_addr == A_STAT);
  assign sink_unused = ^pix_data[RAW_W-9:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_q <= 1'b0;
      frame_q <= 1'b0;
      col <= '0;
      row <= '0;
      capt <= 1'b0;
      bidx <= '0;
      pack <= '0;
      wcnt <= '0;
    end else begin
      line_q  <= line_act;
      frame_q <= frame_act;
      col     <= line_act ? col + 1'b1 : '0;
      if (f_start)                row <= '0;
      else if (line_q & ~line_act) row <= row + 1'b1;
      if (f_end)     capt <= 1'b0;
      else if (take) capt <= 1'b1;
      if (fin)         bidx <= '0;
      else if (accept) bidx <= bidx + 1'b1;
      if (accept) pack[8*bidx +: 8] <= byte_in;
      if (take)      wcnt <= '0;
      else if (emit) wcnt <= wcnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_valid <= 1'b0;
      word_data  <= '0;
    end else if (emit) begin
      word_valid <= 1'b1;
      word_data  <= {byte_in, pack};
    end else if (word_ready) begin
      word_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {fpol, lpol, skip, cont, en} <= '0;
      x0 <= '0; y0 <= '0; w <= '0; h <= '0;
      limit <= '1;
      st_done <= 1'b0; st_ovr <= 1'b0; st_part <= 1'b0;
    end else begin
      if (cfg_we && cfg_addr == A_CTRL) {fpol, lpol, skip, cont, en} <= cfg_wdata[4:0];
      if (cfg_we && cfg_addr == A_ORG) begin
        x0 <= cfg_wdata[COORD_W-1:0];
        y0 <= cfg_wdata[16 +: COORD_W];
      end
      if (cfg_we && cfg_addr == A_SIZE) begin
        w <= cfg_wdata[COORD_W-1:0];
        h <= cfg_wdata[16 +: COORD_W];
      end
      if (cfg_we && cfg_addr == A_LIM) limit <= cfg_wdata[WCNT_W-1:0];
      if (fin && !cont) en <= 1'b0;
      st_done <= (st_done & ~(stat_wr & cfg_wdata[0])) | fin;
      st_ovr  <= (st_ovr  & ~(stat_wr & cfg_wdata[1])) | drop;
      st_part <= (st_part & ~(stat_wr & cfg_wdata[2])) | (fin & (bidx != 2'd0));
    end
  end

  always_comb begin
    cfg_rdata = '0;
    case (cfg_addr)
      A_CTRL: cfg_rdata[4:0] = {fpol, lpol, skip, cont, en};
      A_STAT: cfg_rdata[2:0] = {st_part, st_ovr, st_done};
      A_ORG:  begin cfg_rdata[COORD_W-1:0] = x0; cfg_rdata[16 +: COORD_W] = y0; end
      A_SIZE: begin cfg_rdata[COORD_W-1:0] = w;  cfg_rdata[16 +: COORD_W] = h;  end
      A_LIM:  cfg_rdata[WCNT_W-1:0] = limit;
      default: cfg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/cam_capture_sva.sv
`timescale 1ns/1ps
module cam_capture_sva #(
  parameter int WCNT_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              word_valid,
  input logic              word_ready,
  input logic [31:0]       word_data,
  input logic              en,
  input logic              cont,
  input logic              capt,
  input logic              frame_act,
  input logic              frame_q,
  input logic [1:0]        bidx,
  input logic              complete,
  input logic              st_done,
  input logic              st_ovr,
  input logic              st_part,
  input logic [WCNT_W-1:0] wcnt,
  input logic [WCNT_W-1:0] limit
);
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid && !word_ready |=> word_valid && $stable(word_data));

  assert_snapshot_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    capt && !cont && frame_q && !frame_act |=> !en);

  assert_done_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    capt && frame_q && !frame_act |=> st_done);

  assert_budget_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(word_valid) |-> (wcnt != '0) && (wcnt <= limit));

  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    complete && word_valid && !word_ready |=> st_ovr);

  assert_partial_R11: assert property (@(posedge clk) disable iff (!rst_n)
    capt && frame_q && !frame_act && (bidx != 2'd0) |=> st_part && (bidx == 2'd0));
endmodule

bind cam_capture cam_capture_sva #(.WCNT_W(WCNT_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .word_valid(word_valid), .word_ready(word_ready),
  .word_data(word_data), .en(en), .cont(cont), .capt(capt), .frame_act(frame_act),
  .frame_q(frame_q), .bidx(bidx), .complete(complete), .st_done(st_done),
  .st_ovr(st_ovr), .st_part(st_part), .wcnt(wcnt), .limit(limit)
);

// File: tb/cam_capture_tb.sv
`timescale 1ns/1ps
module cam_capture_tb;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n;
  logic [9:0]  pix_data;
  logic        line_sync, frame_sync;
  logic        cfg_we;
  logic [2:0]  cfg_addr;
  logic [31:0] cfg_wdata, cfg_rdata;
  logic        word_valid, word_ready;
  logic [31:0] word_data;

  cam_capture u_dut (
    .clk(clk), .rst_n(rst_n), .pix_data(pix_data), .line_sync(line_sync),
    .frame_sync(frame_sync), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .word_valid(word_valid),
    .word_ready(word_ready), .word_data(word_data)
  );

  int checks = 0, failures = 0;
  logic [31:0] expq[$];
  int X0, Y0, W, H, LIM;
  bit FP, LP, SKIP, STALL;
  int rmode = 0;
  int cyc = 0;
  bit exp_done, exp_ovr, exp_part;

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #1;
    cyc++;
    case (rmode)
      0: word_ready = 1'b1;
      1: word_ready = (cyc % 3) != 0;
      default: word_ready = 1'b0;
    endcase
  end

  bit stall_q = 0;
  logic [31:0] held;
  always @(negedge clk) begin
    if (rst_n) begin
      if (stall_q) chk(word_valid && word_data == held, "R2 hold while stalled", word_data, held);
      if (word_valid && word_ready) begin
        if (expq.size() == 0) chk(0, "R2 unexpected word", word_data, 0);
        else begin
          logic [31:0] e;
          e = expq.pop_front();
          chk(word_data == e, "R1 R2 word content", word_data, e);
        end
      end
      stall_q = word_valid && !word_ready;
      held = word_data;
    end
  end

  task automatic drv(bit fa, bit la, logic [9:0] v);
    frame_sync = FP ? fa : !fa;
    line_sync  = LP ? la : !la;
    pix_data   = v;
    @(negedge clk);
  endtask

  task automatic cfg_write(logic [2:0] a, logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    cfg_addr = a;
    #1;
    d = cfg_rdata;
  endtask

  task automatic set_mode(logic [4:0] c);
    cfg_write(0, {27'b0, FP, LP, 3'b0});
    FP = c[4]; LP = c[3]; SKIP = c[2];
    frame_sync = !FP; line_sync = !LP;
    cfg_write(0, {27'b0, c & 5'h1C});
    repeat (3) drv(0, 0, 0);
    cfg_write(0, {27'b0, c});
    cfg_write(1, 7);
    exp_done = 0; exp_ovr = 0; exp_part = 0;
  endtask

  task automatic set_win(int x0, int y0, int w, int h);
    X0 = x0; Y0 = y0; W = w; H = h;
    cfg_write(2, {y0[15:0], x0[15:0]});
    cfg_write(3, {h[15:0], w[15:0]});
  endtask

  task automatic send_frame(int cols, int rows, int fr, bit cap, int midctrl);
    int nb = 0, wf = 0;
    logic [31:0] acc = 0;
    drv(0, 0, 0); drv(1, 0, 0); drv(1, 0, 0);
    for (int y = 0; y < rows; y++) begin
      for (int x = 0; x < cols; x++) begin
        logic [7:0] b;
        logic [1:0] lo;
        b  = 8'((x * 5 + y * 17 + fr * 3 + 1) & 255);
        lo = 2'((x ^ y) & 3);
        if (midctrl >= 0 && y == 1 && x == 0) begin
          cfg_we = 1; cfg_addr = 0; cfg_wdata = midctrl;
        end else cfg_we = 0;
        if (cap && x >= X0 && x < X0 + W && y >= Y0 && y < Y0 + H && (!SKIP || ((x - X0) % 2 == 0))) begin
          acc[8 * (nb % 4) +: 8] = b;
          nb++;
          if (nb % 4 == 0) begin
            if ((STALL && wf >= 1) || wf >= LIM) exp_ovr = 1;
            else begin expq.push_back(acc); wf++; end
          end
        end
        drv(1, 1, {b, lo});
      end
      cfg_we = 0;
      repeat (3) drv(1, 0, 0);
    end
    repeat (4) drv(0, 0, 0);
    if (cap) begin
      exp_done = 1;
      if (nb % 4 != 0) exp_part = 1;
    end
  endtask

  task automatic check_status(string req);
    logic [31:0] d;
    logic [2:0] e;
    e = {exp_part, exp_ovr, exp_done};
    rd(1, d);
    chk(d[2:0] == e, req, d[2:0], e);
    cfg_write(1, 7);
    rd(1, d);
    chk(d[2:0] == 0, "R8 status write-one-clear", d[2:0], 0);
    exp_done = 0; exp_ovr = 0; exp_part = 0;
  endtask

  task automatic drain(string req);
    rmode = 0;
    repeat (12) drv(0, 0, 0);
    chk(expq.size() == 0, req, expq.size(), 0);
  endtask

  initial begin
    #(5.0 * 150000);
    chk(0, "watchdog expired", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] d;
    FP = 1; LP = 1; SKIP = 0; STALL = 0; LIM = 65535;
    rst_n = 0; cfg_we = 0; cfg_addr = 0; cfg_wdata = 0;
    pix_data = 0; frame_sync = 0; line_sync = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    chk(word_valid == 0, "R12 word_valid after reset", word_valid, 0);
    rd(0, d); chk(d == 0, "R12 CTRL after reset", d, 0);
    rd(1, d); chk(d == 0, "R12 STATUS after reset", d, 0);
    rd(4, d); chk(d == 32'hFFFF, "R12 LIMIT after reset", d, 32'hFFFF);

    // R1 R2 R3 R6: active-high syncs, full frame, continuous, periodic stall
    rmode = 1;
    set_win(0, 0, 8, 4);
    set_mode(5'h1B);
    send_frame(8, 4, 0, 1, -1);
    send_frame(8, 4, 1, 1, -1);
    drain("R6 continuous frames fully delivered");
    check_status("R8 done after continuous frames");

    // R3 R4: active-low syncs, cropped window
    set_win(2, 1, 4, 2);
    set_mode(5'h03);
    send_frame(10, 4, 2, 1, -1);
    drain("R4 crop window words");
    check_status("R3 R4 status after low-active crop frame");

    // R5: byte decimation
    set_win(1, 0, 8, 2);
    set_mode(5'h1F);
    send_frame(10, 3, 3, 1, -1);
    drain("R5 decimated words");
    check_status("R5 status after decimated frame");

    // R6: enable set mid-frame waits for next frame start
    set_win(0, 0, 8, 2);
    set_mode(5'h1A);
    send_frame(8, 3, 4, 0, 5'h1B);
    drain("R6 no capture of frame in progress");
    check_status("R6 no done flag for skipped frame");
    send_frame(8, 2, 5, 1, -1);
    drain("R6 capture on next frame");
    check_status("R6 done after next frame");

    // R7: snapshot
    set_mode(5'h19);
    send_frame(8, 2, 6, 1, -1);
    drain("R7 snapshot frame words");
    rd(0, d); chk(d == 32'h18, "R7 enable self-clears", d, 32'h18);
    check_status("R7 snapshot done");
    send_frame(8, 2, 7, 0, -1);
    drain("R7 no second snapshot frame");
    check_status("R7 no done after stop");

    // R9: word budget
    LIM = 2;
    cfg_write(4, 2);
    set_mode(5'h1B);
    send_frame(8, 2, 8, 1, -1);
    drain("R9 only budgeted words");
    check_status("R9 overrun on budget");
    LIM = 65535;
    cfg_write(4, 32'hFFFF);

    // R10: stalled consumer
    rmode = 2; STALL = 1;
    send_frame(8, 2, 9, 1, -1);
    STALL = 0;
    drain("R10 only first word kept while stalled");
    check_status("R10 overrun on stall");

    // R11: partial word then aligned next frame
    set_win(0, 0, 6, 1);
    send_frame(8, 2, 10, 1, -1);
    drain("R11 full word before partial");
    check_status("R11 partial error");
    set_win(0, 0, 8, 1);
    send_frame(8, 2, 11, 1, -1);
    drain("R11 next frame realigned");
    check_status("R11 clean frame after partial");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule